// File: doc/BRIEF.md
# Three-Phase Rotating-Frame Phase Tracker with Moving-Average Loop Filter

This block estimates the phase angle and frequency of the fundamental positive-sequence component of a three-phase voltage set. It is built for grid-synchronised power converters. On every sample strobe it rotates the three phase samples into a frame aligned with its own phase estimate. The quadrature component of that frame is the phase error, and the in-phase component is a measure of amplitude.

The phase error is averaged over a window of the last N samples, including the newest one. Choosing N·Ts equal to half a fundamental period places notches on every even harmonic of the ripple. The averaged error drives a discrete proportional-integral compensator with transfer function K(z−α)/(z−1). The default tuning is K = 313 and α = 0.99565, at 12 kHz sampling and N = 100. The compensator output is added to a nominal per-sample phase increment, and the sum is accumulated into a binary angle that wraps at full scale. All arithmetic is fixed point. The sine and cosine values of the estimate and of its ±120° offsets come from one computed quarter-wave table.

Top module: `srf_ma_pll`

## Requirements
- R1: While the reset input is low, phase_o, freq_o, amp_o and valid_o are zero. Reset also clears the filter history, the running sum and the integrator, so a run with zero inputs after reset behaves exactly as R4 states, whatever ran before.
- R2: In a cycle without sample_en, the inputs have no effect: phase_o, freq_o and amp_o hold their values, and the loop state is unchanged at the next strobe.
- R3: valid_o is high in exactly the cycle after a cycle with sample_en high, and low otherwise.
- R4: On every strobe, phase_o advances by exactly freq_o modulo 2^PHW. With all three inputs zero after reset, freq_o equals NOM_INC (83886, which is 60 Hz at 12 kHz with a 24-bit angle) and amp_o is 0.
- R5: With a balanced positive-sequence input va = A·cos ψ, vb = A·cos(ψ−120°), vc = A·cos(ψ+120°), A = 16384, the loop locks from any start phase. After 15 periods, phase_o (0 to 2^24 for one turn) is within 1.5° of ψ at the next sample.
- R6: When locked, amp_o is within 2% of A.
- R7: After a 40° step of ψ, the phase error is within 1.5° after 6 periods.
- R8: After a 60 Hz to 61 Hz step, freq_o·fs/2^24 is within 0.1 Hz of 61 Hz after 8 periods, and the phase error is within 1.5°.
- R9: After a step to half amplitude, combined with a 40° jump and 10% fifth (negative sequence) and seventh (positive sequence) harmonics, the phase error is within 2° after 12 periods.
- R10: With those harmonics present and the loop settled, the reported frequency stays within 0.3 Hz of 60 Hz and the phase error within 2° over a full period, because the window cancels the sixth-harmonic ripple in the error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, releases synchronously |
| sample_en | input | 1 | Sample strobe; all state updates happen only here |
| va_i | input | DW | Phase a sample, signed |
| vb_i | input | DW | Phase b sample, signed |
| vc_i | input | DW | Phase c sample, signed |
| phase_o | output | PHW | Estimated phase as a binary angle (full scale = 360°) |
| freq_o | output | PHW | Phase increment per sample; Hz = freq_o·fs/2^PHW |
| amp_o | output | DW+2 | In-phase frame component, signed; the amplitude indication |
| valid_o | output | 1 | High in the cycle after a strobe |

## Verification
The checker watches four rules on every cycle. Outputs are zero under reset. Outputs hold between strobes. valid_o follows the strobe by one cycle. Every update advances the phase by exactly the reported increment. Whether the loop actually locks, rejects harmonics and settles in time can only be shown by the bench scenarios: the start from a random phase, the phase jump, the frequency step, and the sag with harmonics, each compared with a reference angle the bench computes itself. The exact zero-input sequence after each reset shows that the history and the integrator were cleared.

// File: rtl/srf_pll_pkg.sv
package srf_pll_pkg;

  // pi/2 in Q30
  localparam longint HALF_PI_Q30 = 64'sd1686629713;

  // Quarter-wave sine sample: idx in [0, 2^la] maps to [0, pi/2].
  // Odd Taylor series to the ninth power in Q30, scaled to 2^amp_bits.
  function automatic longint quarter_sine(input longint idx, input int la, input int amp_bits);
    longint a;
    longint a2;
    longint t;
    longint s;
    a  = (idx * HALF_PI_Q30) >>> la;
    a2 = (a * a) >>> 30;
    s  = a;
    t  = a;
    t  = ((t * a2) >>> 30) / 6;
    s  = s - t;
    t  = ((t * a2) >>> 30) / 20;
    s  = s + t;
    t  = ((t * a2) >>> 30) / 42;
    s  = s - t;
    t  = ((t * a2) >>> 30) / 72;
    s  = s + t;
    return (s * (64'sd1 <<< amp_bits) + (64'sd1 <<< 29)) >>> 30;
  endfunction

endpackage

// File: rtl/pll_sine_rom.sv
module pll_sine_rom #(
  parameter int PHW = 24,
  parameter int CW  = 16,
  parameter int LA  = 8,
  parameter int NP  = 6
) (
  input  logic [NP-1:0][PHW-1:0] ang_i,
  output logic [NP-1:0][CW-1:0]  sin_o
);
  import srf_pll_pkg::*;

  localparam int QN = 1 << LA;
  localparam int HW = PHW - LA - 2;
  localparam logic [PHW-1:0] RND = PHW'(1) << (HW - 1);

  logic signed [CW-1:0] tbl [QN+1];

  for (genvar g = 0; g <= QN; g++) begin : g_tab
    localparam longint VAL = quarter_sine(longint'(g), LA, CW - 2);
    assign tbl[g] = CW'(VAL);
  end

  for (genvar p = 0; p < NP; p++) begin : g_port
    logic [LA+1:0]        top;
    logic [LA:0]          eff;
    logic signed [CW-1:0] mag;
    always_comb begin
      top = (LA+2)'((ang_i[p] + RND) >> HW);
      if (top[LA]) eff = (LA+1)'(QN) - {1'b0, top[LA-1:0]};
      else         eff = {1'b0, top[LA-1:0]};
      mag = tbl[eff];
      sin_o[p] = top[LA+1] ? CW'(-mag) : mag;
    end
  end

endmodule

// File: rtl/pll_dq_xform.sv
module pll_dq_xform #(
  parameter int DW  = 16,
  parameter int CW  = 16,
  parameter int PHW = 24,
  parameter int LA  = 8
) (
  input  logic [PHW-1:0]        theta_i,
  input  logic signed [DW-1:0]  va_i,
  input  logic signed [DW-1:0]  vb_i,
  input  logic signed [DW-1:0]  vc_i,
  output logic signed [DW+1:0]  d_o,
  output logic signed [DW+1:0]  q_o
);
  localparam int PW = DW + CW + 2;
  localparam int MW = PW + 18;
  localparam int SH = 16 + CW - 2;
  localparam logic [PHW-1:0] T3  = PHW'(((64'd1 << PHW) + 64'd1) / 64'd3);
  localparam logic [PHW-1:0] QTR = PHW'(64'd1 << (PHW - 2));
  localparam logic signed [17:0] TWO3 = 18'sd43691;

  logic [5:0][PHW-1:0] ang;
  logic [5:0][CW-1:0]  trig;
  logic signed [DW-1:0] v [3];
  logic signed [PW-1:0] sum_c;
  logic signed [PW-1:0] sum_s;
  logic signed [MW-1:0] d_full;
  logic signed [MW-1:0] q_full;

  assign v[0] = va_i;
  assign v[1] = vb_i;
  assign v[2] = vc_i;

  assign ang[0] = theta_i;
  assign ang[1] = theta_i - T3;
  assign ang[2] = theta_i + T3;
  assign ang[3] = theta_i + QTR;
  assign ang[4] = theta_i - T3 + QTR;
  assign ang[5] = theta_i + T3 + QTR;

  pll_sine_rom #(.PHW(PHW), .CW(CW), .LA(LA), .NP(6)) i_rom (
    .ang_i(ang),
    .sin_o(trig)
  );

  logic signed [DW+CW-1:0] pc [3];
  logic signed [DW+CW-1:0] ps [3];

  for (genvar k = 0; k < 3; k++) begin : g_mul
    assign ps[k] = (DW+CW)'(v[k]) * (DW+CW)'($signed(trig[k]));
    assign pc[k] = (DW+CW)'(v[k]) * (DW+CW)'($signed(trig[k+3]));
  end

  assign sum_c  = PW'(pc[0]) + PW'(pc[1]) + PW'(pc[2]);
  assign sum_s  = PW'(ps[0]) + PW'(ps[1]) + PW'(ps[2]);
  assign d_full = MW'(sum_c) * MW'(TWO3);
  assign q_full = MW'(-sum_s) * MW'(TWO3);
  assign d_o    = (DW+2)'(d_full >>> SH);
  assign q_o    = (DW+2)'(q_full >>> SH);

endmodule

// File: rtl/pll_ma_filter.sv
module pll_ma_filter #(
  parameter int W  = 18,
  parameter int N  = 100,
  parameter int RS = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic signed [W-1:0] x_i,
  output logic signed [W-1:0] avg_o
);
  localparam int PTRW = (N > 1) ? $clog2(N) : 1;
  localparam int SW   = W + $clog2(N) + 1;
  localparam int MW   = SW + RS + 1;
  localparam logic signed [RS+1:0] RECIP = (RS+2)'(((64'd1 << RS) + 64'(N / 2)) / 64'(N));

  logic signed [W-1:0]  hist [N];
  logic [PTRW-1:0]      ptr;
  logic [PTRW-1:0]      ptr_nx;
  logic signed [SW-1:0] sum;
  logic signed [SW-1:0] sum_nx;
  logic signed [MW-1:0] prod;

  always_comb begin
    sum_nx = sum + SW'(x_i) - SW'(hist[ptr]);
    ptr_nx = (ptr == PTRW'(N - 1)) ? '0 : ptr + PTRW'(1);
    prod   = MW'(sum_nx) * MW'(RECIP);
    avg_o  = W'(prod >>> RS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) hist[i] <= '0;
      ptr <= '0;
      sum <= '0;
    end else if (en) begin
      hist[ptr] <= x_i;
      ptr       <= ptr_nx;
      sum       <= sum_nx;
    end
  end

endmodule

// File: rtl/pll_pi_nco.sv
module pll_pi_nco #(
  parameter int W   = 18,
  parameter int PHW = 24,
  parameter int IW  = 48,
  parameter int GW  = 24,
  parameter int KP  = 277378,
  parameter int KI  = 1212,
  parameter int GSH = 16,
  parameter int NOM = 83886
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic signed [W-1:0] e_i,
  output logic [PHW-1:0]      theta_o,
  output logic [PHW-1:0]      inc_o
);
  localparam logic signed [GW-1:0] KP_S  = GW'(KP);
  localparam logic signed [GW-1:0] KI_S  = GW'(KI);
  localparam logic [PHW-1:0]       NOM_U = PHW'(NOM);

  logic signed [IW-1:0] integ;
  logic signed [IW-1:0] integ_nx;
  logic signed [IW-1:0] p_term;
  logic signed [IW-1:0] i_step;
  logic signed [IW-1:0] u_full;
  logic [PHW-1:0]       theta;
  logic [PHW-1:0]       theta_nx;

  always_comb begin
    p_term   = IW'(e_i) * IW'(KP_S);
    i_step   = IW'(e_i) * IW'(KI_S);
    u_full   = p_term + integ;
    inc_o    = NOM_U + PHW'(u_full >>> GSH);
    integ_nx = integ + i_step;
    theta_nx = theta + inc_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      integ <= '0;
      theta <= '0;
    end else if (en) begin
      integ <= integ_nx;
      theta <= theta_nx;
    end
  end

  assign theta_o = theta;

endmodule

// File: rtl/srf_ma_pll.sv
module srf_ma_pll #(
  parameter int DW      = 16,
  parameter int PHW     = 24,
  parameter int CW      = 16,
  parameter int LA      = 8,
  parameter int N       = 100,
  parameter int NOM_INC = 83886,
  parameter int KP_Q16  = 277378,
  parameter int KI_Q16  = 1212
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_en,
  input  logic signed [DW-1:0] va_i,
  input  logic signed [DW-1:0] vb_i,
  input  logic signed [DW-1:0] vc_i,
  output logic [PHW-1:0]      phase_o,
  output logic [PHW-1:0]      freq_o,
  output logic signed [DW+1:0] amp_o,
  output logic                valid_o
);
  localparam int XW = DW + 2;

  logic [1:0]           rst_pipe;
  logic                 rst_sync_n;
  logic [PHW-1:0]       theta;
  logic [PHW-1:0]       inc;
  logic signed [XW-1:0] d_val;
  logic signed [XW-1:0] q_val;
  logic signed [XW-1:0] q_avg;

  logic [PHW-1:0]       freq_q;
  logic [PHW-1:0]       freq_nx;
  logic signed [XW-1:0] amp_q;
  logic signed [XW-1:0] amp_nx;
  logic                 vld_q;
  logic                 vld_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  pll_dq_xform #(.DW(DW), .CW(CW), .PHW(PHW), .LA(LA)) i_dq (
    .theta_i(theta),
    .va_i(va_i),
    .vb_i(vb_i),
    .vc_i(vc_i),
    .d_o(d_val),
    .q_o(q_val)
  );

  pll_ma_filter #(.W(XW), .N(N), .RS(24)) i_ma (
    .clk(clk),
    .rst_n(rst_sync_n),
    .en(sample_en),
    .x_i(q_val),
    .avg_o(q_avg)
  );

  pll_pi_nco #(
    .W(XW), .PHW(PHW), .IW(48), .GW(24),
    .KP(KP_Q16), .KI(KI_Q16), .GSH(16), .NOM(NOM_INC)
  ) i_loop (
    .clk(clk),
    .rst_n(rst_sync_n),
    .en(sample_en),
    .e_i(q_avg),
    .theta_o(theta),
    .inc_o(inc)
  );

  always_comb begin
    freq_nx = freq_q;
    amp_nx  = amp_q;
    vld_nx  = 1'b0;
    if (sample_en) begin
      freq_nx = inc;
      amp_nx  = d_val;
      vld_nx  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      freq_q <= '0;
      amp_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      freq_q <= freq_nx;
      amp_q  <= amp_nx;
      vld_q  <= vld_nx;
    end
  end

  assign phase_o = theta;
  assign freq_o  = freq_q;
  assign amp_o   = amp_q;
  assign valid_o = vld_q;

endmodule

// File: rtl/srf_ma_pll_sva.sv
module srf_ma_pll_sva #(
  parameter int PHW = 24,
  parameter int AW  = 18
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sample_en,
  input logic [PHW-1:0]       phase_o,
  input logic [PHW-1:0]       freq_o,
  input logic signed [AW-1:0] amp_o,
  input logic                 valid_o
);

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |-> (phase_o == '0 && freq_o == '0 && amp_o == '0 && !valid_o));

  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> ($stable(phase_o) && $stable(freq_o) && $stable(amp_o)));

  p_valid_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |=> valid_o);

  p_valid_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> !valid_o);

  p_phase_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (phase_o == PHW'($past(phase_o) + freq_o)));

endmodule

bind srf_ma_pll srf_ma_pll_sva #(.PHW(PHW), .AW(DW + 2)) i_sva (
  .clk(clk),
  .rst_n(rst_sync_n),
  .sample_en(sample_en),
  .phase_o(phase_o),
  .freq_o(freq_o),
  .amp_o(amp_o),
  .valid_o(valid_o)
);

// File: tb/test_srf_ma_pll.sv
module test_srf_ma_pll;

  localparam real FS    = 12000.0;
  localparam real SCALE = 16777216.0;
  localparam real AREF  = 16384.0;
  localparam int  SPP   = 200;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               sample_en;
  logic signed [15:0] va, vb, vc;
  logic [23:0]        phase_o, freq_o;
  logic signed [17:0] amp_o;
  logic               valid_o;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;
  real psi    = 0.0;
  real f_in   = 60.0;
  real err_deg, f_hz;
  longint nom_exp;

  always #5 clk = ~clk;

  srf_ma_pll i_srf_ma_pll (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en),
    .va_i(va), .vb_i(vb), .vc_i(vc),
    .phase_o(phase_o), .freq_o(freq_o), .amp_o(amp_o), .valid_o(valid_o)
  );

  function automatic int rnd(input real x);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  function automatic real wrap180(input real x);
    real y;
    y = x;
    while (y > 180.0)   y = y - 360.0;
    while (y <= -180.0) y = y + 360.0;
    return y;
  endfunction

  function automatic real absr(input real x);
    return (x < 0.0) ? -x : x;
  endfunction

  function automatic real ph_deg(input logic [23:0] p);
    return real'(p) * 360.0 / SCALE;
  endfunction

  task automatic chk(input string req, input bit ok, input string what);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s", req, what);
    end
  endtask

  // one strobe: drive at a falling edge, sample at the next falling edge
  task automatic sample(input real a1, input real h);
    real r, w;
    real ang [3];
    r = 3.14159265358979 / 180.0;
    ang[0] = psi; ang[1] = psi - 120.0; ang[2] = psi + 120.0;
    @(negedge clk);
    w = a1 * $cos(ang[0] * r) + h * $cos(5.0 * ang[0] * r) + h * $cos(7.0 * ang[0] * r);
    va = 16'(rnd(w));
    w = a1 * $cos(ang[1] * r) + h * $cos(5.0 * ang[1] * r) + h * $cos(7.0 * ang[1] * r);
    vb = 16'(rnd(w));
    w = a1 * $cos(ang[2] * r) + h * $cos(5.0 * ang[2] * r) + h * $cos(7.0 * ang[2] * r);
    vc = 16'(rnd(w));
    sample_en = 1'b1;
    @(negedge clk);
    sample_en = 1'b0;
    psi = psi + 360.0 * f_in / FS;
    if (psi >= 360.0) psi = psi - 360.0;
    err_deg = wrap180(ph_deg(phase_o) - psi);
    f_hz = real'(freq_o) * FS / SCALE;
  endtask

  task automatic run(input int n, input real a1, input real h);
    for (int i = 0; i < n; i++) sample(a1, h);
  endtask

  task automatic zero_run(input int n, input string req);
    for (int i = 1; i <= n; i++) begin
      longint e;
      sample(0.0, 0.0);
      e = (longint'(i) * nom_exp) % 64'd16777216;
      chk(req, valid_o == 1'b1, $sformatf("R3 valid act=%0d exp=1", valid_o));
      chk(req, longint'(phase_o) == e, $sformatf("phase act=%0d exp=%0d", phase_o, e));
      chk(req, longint'(freq_o) == nom_exp && amp_o == 0,
          $sformatf("freq act=%0d exp=%0d amp act=%0d exp=0", freq_o, nom_exp, amp_o));
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", phase_o == 0 && freq_o == 0 && amp_o == 0 && valid_o == 0,
        $sformatf("reset outputs act=%0d/%0d/%0d/%0d exp=0", phase_o, freq_o, amp_o, valid_o));
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    real max_f, max_e, a_tol;
    logic [23:0] h_ph, h_fr;
    logic signed [17:0] h_am;
    seed = $urandom(32'd770311);
    nom_exp = longint'(rnd(60.0 / FS * SCALE));
    rst_n = 1'b1; sample_en = 1'b0; va = '0; vb = '0; vc = '0;
    #3 rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", phase_o == 0 && freq_o == 0 && amp_o == 0 && valid_o == 0,
        $sformatf("reset outputs act=%0d/%0d/%0d/%0d exp=0", phase_o, freq_o, amp_o, valid_o));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R3", valid_o == 1'b0, $sformatf("valid before strobe act=%0d exp=0", valid_o));

    // R4: exact advance with zero inputs, covers wrap of the angle
    zero_run(300, "R4");

    // R5: lock from a random start phase
    psi = real'($urandom_range(150, 0));
    f_in = 60.0;
    run(15 * SPP, AREF, 0.0);
    chk("R5", absr(err_deg) <= 1.5, $sformatf("phase err act=%f exp=0 tol=1.5", err_deg));
    a_tol = 0.02 * AREF;
    chk("R6", absr(real'(amp_o) - AREF) <= a_tol,
        $sformatf("amplitude act=%0d exp=%f", amp_o, AREF));

    // R2: no strobe, random inputs, outputs must hold
    h_ph = phase_o; h_fr = freq_o; h_am = amp_o;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      va = 16'($urandom); vb = 16'($urandom); vc = 16'($urandom);
      chk("R2", phase_o == h_ph && freq_o == h_fr && amp_o == h_am,
          $sformatf("hold act=%0d/%0d/%0d exp=%0d/%0d/%0d",
                    phase_o, freq_o, amp_o, h_ph, h_fr, h_am));
      chk("R3", valid_o == 1'b0, $sformatf("valid idle act=%0d exp=0", valid_o));
    end
    sample(AREF, 0.0);
    chk("R2", absr(err_deg) <= 1.5, $sformatf("state after idle err act=%f exp=0", err_deg));

    // R7: 40 degree jump
    psi = psi + 40.0;
    run(6 * SPP, AREF, 0.0);
    chk("R7", absr(err_deg) <= 1.5, $sformatf("phase err act=%f exp=0 tol=1.5", err_deg));

    // R8: frequency step to 61 Hz
    f_in = 61.0;
    run(8 * SPP, AREF, 0.0);
    chk("R8", absr(f_hz - 61.0) <= 0.1, $sformatf("freq act=%f exp=61.0", f_hz));
    chk("R8", absr(err_deg) <= 1.5, $sformatf("phase err act=%f exp=0 tol=1.5", err_deg));

    f_in = 60.0;
    run(8 * SPP, AREF, 0.0);

    // R9: sag, jump and harmonics together
    psi = psi + 40.0;
    run(12 * SPP, 0.5 * AREF, 0.1 * AREF);
    chk("R9", absr(err_deg) <= 2.0, $sformatf("phase err act=%f exp=0 tol=2", err_deg));

    // R10: ripple over a full period with harmonics present
    max_f = 0.0; max_e = 0.0;
    for (int i = 0; i < SPP; i++) begin
      sample(0.5 * AREF, 0.1 * AREF);
      if (absr(f_hz - 60.0) > max_f) max_f = absr(f_hz - 60.0);
      if (absr(err_deg) > max_e) max_e = absr(err_deg);
    end
    chk("R10", max_f <= 0.3, $sformatf("freq ripple act=%f exp<=0.3", max_f));
    chk("R10", max_e <= 2.0, $sformatf("phase ripple act=%f exp<=2", max_e));

    // R1: reset in mid-run clears history and integrator
    do_reset();
    zero_run(20, "R1");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule